// File: doc/BRIEF.md
# Sixteen-Bit Timer with Two Compare Channels and Forced Match

This block is a 16-bit up-counter with two compare channels, A and B. Each channel drives one waveform output. When the counter reaches a channel's compare value, the channel sets a status flag and applies its configured action to its output. The possible actions are hold, toggle, drive low and drive high. The counter either runs freely and wraps through zero, raising an overflow flag, or it runs in clear-on-compare mode. In that mode, channel A's compare value is the top of the count.

Each timer tick advances the counter. The tick comes either from an internal count-enable input or from rising edges on an external count pin. Software reaches the block through an 8-bit register bus. All 16-bit quantities pass through one shared staging byte, so each quantity is written or sampled as a whole.

Two features serve software control of the waveform:
- A force strobe applies a channel's action at once. It does not set the channel's flag and does not disturb the counter.
- Any write to the counter suppresses compare matches on the timer tick that follows, so the write cannot fire a channel by itself.

Top module: `tmr16_cmp_unit`

## Requirements
- R1: After reset the counter, both compare values, the staging byte, the control byte and all flags are zero, and both waveform outputs are low.
- R2: Register addresses are 0 control, 1 force, 2/3 counter low/high, 4/5 compare A low/high, 6/7 compare B low/high, and 8 flags. Writing a high address loads only the shared staging byte. Writing a low address stores {staging, data} into the target in one cycle. Reading a low address returns the low half and copies the target's high half into the staging byte. Reading any high address returns the staging byte.
- R3: The counter advances by one on each tick. Control bit 2 = 0 selects the count-enable input as the tick source, and that input advances the counter on each clock where it is high. Control bit 2 = 1 selects the external pin, and then each rising edge of the pin gives one tick while the count-enable input is ignored.
- R4: A tick taken at count 0xFFFF yields count 0 and sets the overflow flag (flag bit 2, also on `irq_ovf`).
- R5: With control bit 0 = 1 (clear-on-compare), a tick at which the count equals compare A and is not suppressed yields count 0.
- R6: On a tick where the count equals a channel's compare value, the block sets that channel's flag (bit 0 for A, bit 1 for B) and updates that channel's output. The output follows the channel's action field: control bits [5:4] for A and [7:6] for B, with 0 hold, 1 toggle, 2 low, 3 high.
- R7: Writing address 8 clears each flag whose data bit is one and leaves the flags whose data bit is zero unchanged.
- R8: Writing a one to bit 0 (A) or bit 1 (B) of address 1 applies that channel's action to its output at the next clock edge.
- R9: A forced compare sets no flag and leaves the counter unchanged.
- R10: While control bit 1 (PWM mode flag) is one, force writes have no effect.
- R11: Address 1 always reads back zero.
- R12: A write to the counter low address suppresses compare matches on the next tick for both channels: no flag, no output action and no clear-on-compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Internal tick enable |
| ext_cnt_pin | input | 1 | External count source, counted on rising edges |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives staging-byte capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |
| irq_a | output | 1 | Channel A compare flag |
| irq_b | output | 1 | Channel B compare flag |
| irq_ovf | output | 1 | Overflow flag |

## Verification
A stuck or stale staging byte shows up at once as a wrong high half. It appears on the next high-address read, or in the value a later low write commits to another register. A suppression state that is left set too long, or cleared too early, shows up on the first tick after a counter write. It appears as a flag, an output edge or a counter clear that should not have happened, or one that is missing. A force path that leaks into the flag or counter logic changes `irq_a`, `irq_b` or the counter value one clock after the force write, where the bench reads them back.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_LOW    = 2'd2,
      ACT_HIGH   = 2'd3
   } wave_act_e;

   localparam int unsigned ADDR_W = 4;

   localparam logic [ADDR_W-1:0] RA_CTRL  = 4'h0;
   localparam logic [ADDR_W-1:0] RA_FORCE = 4'h1;
   localparam logic [ADDR_W-1:0] RA_CNTL  = 4'h2;
   localparam logic [ADDR_W-1:0] RA_CNTH  = 4'h3;
   localparam logic [ADDR_W-1:0] RA_CMPAL = 4'h4;
   localparam logic [ADDR_W-1:0] RA_CMPAH = 4'h5;
   localparam logic [ADDR_W-1:0] RA_CMPBL = 4'h6;
   localparam logic [ADDR_W-1:0] RA_CMPBH = 4'h7;
   localparam logic [ADDR_W-1:0] RA_FLAG  = 4'h8;

   function automatic logic next_wave(input wave_act_e act, input logic cur);
      case (act)
         ACT_TOGGLE: return ~cur;
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr16_regif.sv
module tmr16_regif
   import tmr16_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [CNT_W-1:0]     cnt_val,
   input  logic [2:0]           flag_vec,
   output logic                 mode_ctc,
   output logic                 mode_pwm,
   output logic                 src_ext,
   output wave_act_e            act_a,
   output wave_act_e            act_b,
   output logic [CNT_W-1:0]     cmp_a,
   output logic [CNT_W-1:0]     cmp_b,
   output logic                 cnt_wr,
   output logic [CNT_W-1:0]     cnt_wdata,
   output logic                 force_a,
   output logic                 force_b,
   output logic [2:0]           flag_clr
);

   localparam int unsigned HI_LSB = BUS_W;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("tmr16_regif: CNT_W must equal twice BUS_W");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("tmr16_regif: BUS_W must be at least 8");
      end
   endgenerate

   logic [BUS_W-1:0] stage_q;
   logic [BUS_W-1:0] ctrl_q;
   logic [CNT_W-1:0] cmpa_q;
   logic [CNT_W-1:0] cmpb_q;
   logic [CNT_W-1:0] commit_val;

   assign commit_val = {stage_q, bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         ctrl_q  <= '0;
         cmpa_q  <= '0;
         cmpb_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            RA_CTRL:                    ctrl_q  <= bus_wdata;
            RA_CNTH, RA_CMPAH, RA_CMPBH: stage_q <= bus_wdata;
            RA_CMPAL:                   cmpa_q  <= commit_val;
            RA_CMPBL:                   cmpb_q  <= commit_val;
            default: ;
         endcase
      end else if (bus_rd) begin
         case (bus_addr)
            RA_CNTL:  stage_q <= cnt_val[CNT_W-1:HI_LSB];
            RA_CMPAL: stage_q <= cmpa_q[CNT_W-1:HI_LSB];
            RA_CMPBL: stage_q <= cmpb_q[CNT_W-1:HI_LSB];
            default: ;
         endcase
      end
   end

   always_comb begin
      mode_ctc  = ctrl_q[0];
      mode_pwm  = ctrl_q[1];
      src_ext   = ctrl_q[2];
      act_a     = wave_act_e'(ctrl_q[5:4]);
      act_b     = wave_act_e'(ctrl_q[7:6]);
      cmp_a     = cmpa_q;
      cmp_b     = cmpb_q;
      cnt_wr    = bus_wr && (bus_addr == RA_CNTL);
      cnt_wdata = commit_val;
      force_a   = bus_wr && (bus_addr == RA_FORCE) && bus_wdata[0] && !ctrl_q[1];
      force_b   = bus_wr && (bus_addr == RA_FORCE) && bus_wdata[1] && !ctrl_q[1];
      flag_clr  = (bus_wr && (bus_addr == RA_FLAG)) ? bus_wdata[2:0] : 3'b000;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CTRL:                    bus_rdata = ctrl_q;
         RA_CNTL:                    bus_rdata = cnt_val[BUS_W-1:0];
         RA_CMPAL:                   bus_rdata = cmpa_q[BUS_W-1:0];
         RA_CMPBL:                   bus_rdata = cmpb_q[BUS_W-1:0];
         RA_CNTH, RA_CMPAH, RA_CMPBH: bus_rdata = stage_q;
         RA_FLAG:                    bus_rdata[2:0] = flag_vec;
         default:                    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_ext,
   input  logic int_en,
   input  logic ext_pin,
   output logic tick
);

   logic pin_s;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = ext_pin;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= ext_pin;
         end
         assign pin_s = s_q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], ext_pin};
         end
         assign pin_s = s_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign tick = use_ext ? (pin_s && !prev_q) : int_en;

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  logic                        cnt_wr,
   input  logic [CNT_W-1:0]            cnt_wdata,
   input  logic                        mode_ctc,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
   input  logic                        ovf_clr,
   output logic [CNT_W-1:0]            cnt_q,
   output logic [NUM_CH-1:0]           match,
   output logic                        ovf_flag
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("tmr16_core: NUM_CH must be at least 1");
      end
   endgenerate

   logic blk_q;
   logic live;
   logic top_hit;
   logic wrap;

   assign live    = tick && !cnt_wr && !blk_q;
   assign top_hit = mode_ctc && match[0];
   assign wrap    = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});

   for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
      assign match[g] = live && (cnt_q == cmp[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wdata;
         blk_q <= 1'b1;
      end else if (tick) begin
         blk_q <= 1'b0;
         cnt_q <= top_hit ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/tmr16_wave_ch.sv
module tmr16_wave_ch
   import tmr16_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  wave_act_e act,
   input  logic      match,
   input  logic      force_hit,
   input  logic      flag_clr,
   output logic      wave_q,
   output logic      flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wave_q <= 1'b0;
      else if (match || force_hit) wave_q <= next_wave(act, wave_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (match)    flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

endmodule

// File: rtl/tmr16_cmp_unit.sv
module tmr16_cmp_unit
   import tmr16_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              ext_cnt_pin,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wave_a,
   output logic              wave_b,
   output logic              irq_a,
   output logic              irq_b,
   output logic              irq_ovf
);

   localparam int unsigned NUM_CH = 2;

   logic                         mode_ctc_w;
   logic                         mode_pwm_w;
   logic                         src_ext_w;
   wave_act_e                    act_w [NUM_CH];
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_w;
   logic                         cnt_wr_w;
   logic [CNT_W-1:0]             cnt_wdata_w;
   logic [NUM_CH-1:0]            force_w;
   logic [2:0]                   flag_clr_w;
   logic                         tick_w;
   logic [CNT_W-1:0]             cnt_w;
   logic [NUM_CH-1:0]            match_w;
   logic [NUM_CH-1:0]            wave_w;
   logic [NUM_CH-1:0]            flag_w;
   logic                         ovf_w;

   tmr16_regif #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt_val   (cnt_w),
      .flag_vec  ({ovf_w, flag_w[1], flag_w[0]}),
      .mode_ctc  (mode_ctc_w),
      .mode_pwm  (mode_pwm_w),
      .src_ext   (src_ext_w),
      .act_a     (act_w[0]),
      .act_b     (act_w[1]),
      .cmp_a     (cmp_w[0]),
      .cmp_b     (cmp_w[1]),
      .cnt_wr    (cnt_wr_w),
      .cnt_wdata (cnt_wdata_w),
      .force_a   (force_w[0]),
      .force_b   (force_w[1]),
      .flag_clr  (flag_clr_w)
   );

   tmr16_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .use_ext (src_ext_w),
      .int_en  (cnt_en),
      .ext_pin (ext_cnt_pin),
      .tick    (tick_w)
   );

   tmr16_core #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_w),
      .cnt_wr    (cnt_wr_w),
      .cnt_wdata (cnt_wdata_w),
      .mode_ctc  (mode_ctc_w),
      .cmp       (cmp_w),
      .ovf_clr   (flag_clr_w[2]),
      .cnt_q     (cnt_w),
      .match     (match_w),
      .ovf_flag  (ovf_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr16_wave_ch u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .act       (act_w[c]),
         .match     (match_w[c]),
         .force_hit (force_w[c]),
         .flag_clr  (flag_clr_w[c]),
         .wave_q    (wave_w[c]),
         .flag_q    (flag_w[c])
      );
   end

   assign wave_a  = wave_w[0];
   assign wave_b  = wave_w[1];
   assign irq_a   = flag_w[0];
   assign irq_b   = flag_w[1];
   assign irq_ovf = ovf_w;

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
   import tmr16_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              cnt_wr,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              match_a,
   input logic              match_b,
   input logic              mode_ctc,
   input logic              mode_pwm,
   input logic              wave_a,
   input logic              irq_a,
   input logic              irq_b,
   input logic              irq_ovf,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (cnt_wr) pend_q <= 1'b1;
      else if (tick)   pend_q <= 1'b0;
   end

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !(mode_ctc && match_a)) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R4
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}})) |=> irq_ovf);

   // R5
   ctc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ctc && match_a && !cnt_wr) |=> (cnt_q == '0));

   // R9
   force_no_flag_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_a) |-> $past(match_a));

   // R9
   force_no_flag_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_b) |-> $past(match_b));

   // R10
   pwm_force_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pwm && !match_a) |=> $stable(wave_a));

   // R11
   force_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_FORCE) |-> (bus_rdata == '0));

   // R12
   wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && tick) |-> (!match_a && !match_b));

endmodule

bind tmr16_cmp_unit tmr16_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick_w),
   .cnt_wr    (cnt_wr_w),
   .cnt_q     (cnt_w),
   .match_a   (match_w[0]),
   .match_b   (match_w[1]),
   .mode_ctc  (mode_ctc_w),
   .mode_pwm  (mode_pwm_w),
   .wave_a    (wave_a),
   .irq_a     (irq_a),
   .irq_b     (irq_b),
   .irq_ovf   (irq_ovf),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/sim_tmr16_cmp_unit.sv
module sim_tmr16_cmp_unit;

   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic       ext_cnt_pin = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       wave_a, wave_b, irq_a, irq_b, irq_ovf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr16_cmp_unit u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_cnt_pin(ext_cnt_pin),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wave_a(wave_a), .wave_b(wave_b), .irq_a(irq_a), .irq_b(irq_b),
      .irq_ovf(irq_ovf)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr8(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd8(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
      wr8(lo + 4'd1, v[15:8]);
      wr8(lo, v[7:0]);
   endtask

   task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      rd8(lo, l);
      rd8(lo + 4'd1, h);
      v = {h, l};
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] b; logic [15:0] v;
      check("R1", "wave_a", {15'd0, wave_a}, 16'd0);
      check("R1", "wave_b", {15'd0, wave_b}, 16'd0);
      check("R1", "irqs", {13'd0, irq_ovf, irq_b, irq_a}, 16'd0);
      rd8(4'h0, b); check("R1", "ctrl", {8'd0, b}, 16'd0);
      rd16(4'h2, v); check("R1", "count", v, 16'd0);
      rd16(4'h4, v); check("R1", "cmp_a", v, 16'd0);
   endtask

   task automatic t_stage;
      logic [15:0] v;
      wr16(4'h4, 16'h1234);
      rd16(4'h4, v); check("R2", "cmp_a commit", v, 16'h1234);
      wr8(4'h5, 8'h56);
      rd16(4'h4, v); check("R2", "high write alone not committed", v, 16'h1234);
      wr8(4'h3, 8'hAB);
      wr8(4'h6, 8'h01);
      rd16(4'h6, v); check("R2", "shared staging into cmp_b", v, 16'hAB01);
   endtask

   task automatic t_count_int;
      logic [15:0] v;
      wr16(4'h2, 16'h0010);
      run_ticks(5);
      rd16(4'h2, v); check("R3", "internal ticks", v, 16'h0015);
   endtask

   task automatic t_count_ext;
      logic [15:0] v;
      wr8(4'h0, 8'h04);
      @(negedge clk); cnt_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ext_cnt_pin = 1'b1;
         repeat (3) @(negedge clk);
         ext_cnt_pin = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      cnt_en = 1'b0;
      rd16(4'h2, v); check("R3", "external edges, enable ignored", v, 16'h0019);
      wr8(4'h0, 8'h00);
   endtask

   task automatic t_ovf;
      logic [7:0] b; logic [15:0] v;
      wr16(4'h2, 16'hFFFE);
      run_ticks(2);
      rd16(4'h2, v); check("R4", "wrap to zero", v, 16'h0000);
      check("R4", "irq_ovf", {15'd0, irq_ovf}, 16'd1);
      rd8(4'h8, b); check("R4", "flag reg bit2", {8'd0, b}, 16'h0004);
      wr8(4'h8, 8'h00);
      check("R7", "zero write keeps ovf", {15'd0, irq_ovf}, 16'd1);
      wr8(4'h8, 8'h04);
      check("R7", "ovf cleared", {15'd0, irq_ovf}, 16'd0);
   endtask

   task automatic t_ctc;
      logic [15:0] v;
      wr8(4'h0, 8'hD1);
      wr16(4'h4, 16'h0005);
      wr16(4'h6, 16'h0003);
      wr16(4'h2, 16'h0000);
      run_ticks(6);
      rd16(4'h2, v); check("R5", "ctc wrap at top", v, 16'h0000);
      check("R6", "wave_a toggled", {15'd0, wave_a}, 16'd1);
      check("R6", "wave_b set", {15'd0, wave_b}, 16'd1);
      check("R6", "irq_a", {15'd0, irq_a}, 16'd1);
      check("R6", "irq_b", {15'd0, irq_b}, 16'd1);
      run_ticks(6);
      check("R6", "wave_a toggled back", {15'd0, wave_a}, 16'd0);
      rd16(4'h2, v); check("R5", "second ctc wrap", v, 16'h0000);
   endtask

   task automatic t_clear;
      wr8(4'h8, 8'h00);
      check("R7", "irq_a kept", {15'd0, irq_a}, 16'd1);
      wr8(4'h8, 8'h01);
      check("R7", "irq_a cleared", {15'd0, irq_a}, 16'd0);
      check("R7", "irq_b kept", {15'd0, irq_b}, 16'd1);
      wr8(4'h8, 8'h02);
      check("R7", "irq_b cleared", {15'd0, irq_b}, 16'd0);
   endtask

   task automatic t_force;
      logic [7:0] b; logic [15:0] v;
      wr16(4'h2, 16'h0005);
      wr8(4'h0, 8'h91);
      wr8(4'h1, 8'h03);
      check("R8", "force toggles wave_a", {15'd0, wave_a}, 16'd1);
      check("R8", "force clears wave_b", {15'd0, wave_b}, 16'd0);
      check("R9", "no flags from force", {14'd0, irq_b, irq_a}, 16'd0);
      rd16(4'h2, v); check("R9", "counter kept at top", v, 16'h0005);
      rd8(4'h1, b); check("R11", "force reads zero", {8'd0, b}, 16'd0);
   endtask

   task automatic t_pwm;
      wr8(4'h0, 8'h93);
      wr8(4'h1, 8'h01);
      check("R10", "pwm ignores force a", {15'd0, wave_a}, 16'd1);
      wr8(4'h0, 8'hF3);
      wr8(4'h1, 8'h02);
      check("R10", "pwm ignores force b", {15'd0, wave_b}, 16'd0);
   endtask

   task automatic t_block;
      logic [15:0] v;
      wr8(4'h0, 8'hD1);
      wr16(4'h6, 16'h0007);
      wr8(4'h8, 8'h07);
      wr16(4'h2, 16'h0005);
      run_ticks(1);
      rd16(4'h2, v); check("R12", "no ctc clear after write", v, 16'h0006);
      check("R12", "no flag a", {15'd0, irq_a}, 16'd0);
      check("R12", "wave_a unchanged", {15'd0, wave_a}, 16'd1);
      wr16(4'h2, 16'h0007);
      run_ticks(1);
      rd16(4'h2, v); check("R12", "count past cmp_b", v, 16'h0008);
      check("R12", "no flag b", {15'd0, irq_b}, 16'd0);
      check("R12", "wave_b unchanged", {15'd0, wave_b}, 16'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stage();
      t_count_int();
      t_count_ext();
      t_ovf();
      t_ctc();
      t_clear();
      t_force();
      t_pwm();
      t_block();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule